// File: doc/BRIEF.md
# Selectable-Source Gated Tick Divider

This block derives a slow per-peripheral clock from one of several source rates. Every source is modelled as a stream of one-cycle enable ticks in a single system clock domain. The block picks one stream, divides its tick rate by a programmable ratio, and emits a one-cycle output tick for each completed division. A control register drives three configuration inputs: a source code, a divider field and an enable.

The source code and the divider go into working copies only while the output is stopped. While the output runs, the working copies are frozen, so a peripheral never sees a rate change partway through a period. Software changes the rate by clearing the enable, writing the new fields and setting the enable again. The output is a flop, so it cannot glitch.

Top module: `gen_clk_div`

## Requirements
- R1: While `rst_n` is low, `gen_tick` is 0 and the working source and divider copy `cfg_sel`/`cfg_div`. The values present when reset is released with `cfg_en` high are the ones used.
- R2: For `cfg_sel` codes 0 to 5, only ticks on `src_tick[cfg_sel]` are counted. Ticks on other lanes have no effect on `gen_tick`.
- R3: `cfg_sel` codes 6 and 7 select no source, and `gen_tick` stays 0 whatever the lanes do.
- R4: A divider field of 0 passes every selected tick. A tick sampled at a rising edge raises `gen_tick` for exactly the following cycle.
- R5: A divider field of N gives one `gen_tick` per N+1 selected ticks. After enable, the first output comes on the (N+1)-th selected tick.
- R6: Changes to `cfg_sel` or `cfg_div` while the output runs have no effect. The values sampled at the edge where `cfg_en` is first seen high are used until the next stop.
- R7: When `cfg_en` is sampled low, `gen_tick` is 0 from the next cycle. A partial count is discarded, so counting restarts from zero at the next enable.
- R8: A divider field of 255 gives a ratio of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NUM_SRC (6) | One-cycle enable tick per source, bit i is source code i |
| cfg_sel | input | SEL_W (3) | Source code from the control register |
| cfg_div | input | DIV_W (8) | Divider field, ratio is value plus one |
| cfg_en | input | 1 | Output enable |
| gen_tick | output | 1 | Divided output tick, one cycle wide |

## Verification
The hardest case to reach is a configuration write that lands while the output is running, because it must leave no trace. The bench enables one lane, rewrites both fields in mid-stream, and counts output ticks on the old lane and then on the new lane. It then restarts the enable and shows that the new values apply only after that. A second hard case discards a partial count: the bench stops the output one tick short of a full period, re-enables, and expects no output until a whole new period has passed.

// File: rtl/gcd_pkg.sv
// Shared helpers for the selectable-source tick divider.
// Assumes source codes are plain binary indices into the tick vector.
package gcd_pkg;

    // True when a code names an implemented source lane.
    function automatic logic code_valid(input int unsigned code, input int unsigned n_src);
        return code < n_src;
    endfunction

endpackage

// File: rtl/gcd_cfg_hold.sv
// Run flag and working copies of source code and divider.
// The copies track the request inputs while the output is stopped, including
// during reset, and freeze for as long as the output runs.
module gcd_cfg_hold #(
    parameter int SEL_W = 3,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_en,
    output logic             run_q,
    output logic [SEL_W-1:0] act_sel,
    output logic [DIV_W-1:0] act_div
);

    // Run flag follows the enable with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= cfg_en;
    end

    // Working copies load only while stopped or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) begin
            act_sel <= cfg_sel;
            act_div <= cfg_div;
        end
    end

endmodule

// File: rtl/gcd_src_mux.sv
// One-hot lane match between the working source code and the tick lanes.
// Codes at or above NUM_SRC match no lane, so they yield no ticks.
module gcd_src_mux #(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   act_sel,
    output logic               sel_tick
);

    logic [NUM_SRC-1:0] lane_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        // Lane g passes its tick only when the working code names it.
        assign lane_hit[g] = src_tick[g] && (act_sel == SEL_W'(g));
    end

    assign sel_tick = |lane_hit;

endmodule

// File: rtl/gcd_tick_count.sv
// Counts selected ticks modulo (act_div + 1) and registers the output tick.
// Assumes act_div is frozen while run_q is high. The counter is held at zero
// while stopped. The live enable also gates the output so it stops at once.
module gcd_tick_count #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic             cfg_en,
    input  logic             sel_tick,
    input  logic [DIV_W-1:0] act_div,
    output logic [DIV_W-1:0] cnt,
    output logic             gen_tick
);

    logic terminal;
    assign terminal = (cnt == act_div);

    // Position inside the current division period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) cnt <= '0;
        else if (sel_tick)    cnt <= terminal ? '0 : cnt + 1'b1;
    end

    // Output tick: last selected tick of a period while running and enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_tick <= 1'b0;
        else        gen_tick <= run_q && cfg_en && sel_tick && terminal;
    end

endmodule

// File: rtl/gen_clk_div.sv
// Top of the selectable-source gated tick divider.
// One clock domain. Sources are one-cycle tick streams in that domain.
module gen_clk_div #(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 3,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_en,
    output logic               gen_tick
);

    logic             run_q;
    logic [SEL_W-1:0] act_sel;
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] cnt;
    logic             sel_tick;

    gcd_cfg_hold #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_div(cfg_div),
        .cfg_en(cfg_en), .run_q(run_q), .act_sel(act_sel), .act_div(act_div)
    );

    gcd_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .src_tick(src_tick), .act_sel(act_sel), .sel_tick(sel_tick)
    );

    gcd_tick_count #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .cfg_en(cfg_en),
        .sel_tick(sel_tick), .act_div(act_div), .cnt(cnt), .gen_tick(gen_tick)
    );

endmodule

// File: rtl/gen_clk_div_chk.sv
// Property checker for gen_clk_div, bound to every instance of the top.
module gen_clk_div_chk
    import gcd_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 3,
    parameter int DIV_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               cfg_en,
    input logic               gen_tick,
    input logic               run_q,
    input logic [SEL_W-1:0]   act_sel,
    input logic [DIV_W-1:0]   act_div,
    input logic [DIV_W-1:0]   cnt
);

    // R6: working settings stay frozen while running
    a_r6_frozen_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cfg_en) |=> ($stable(act_sel) && $stable(act_div)));

    // R7: no output in the cycle after the enable is seen low
    a_r7_stop_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !gen_tick);

    // R7: every run starts from a cleared count
    a_r7_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt == '0));

    // R3: invalid source code never yields an output tick
    a_r3_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid(int'(act_sel), NUM_SRC) |=> !gen_tick);

    // R2: an output tick always follows some source tick
    a_r2_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        gen_tick |-> $past(|src_tick));

    // R5: count never passes the divider field while running
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt <= act_div));

endmodule

bind gen_clk_div gen_clk_div_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_en(cfg_en),
    .gen_tick(gen_tick), .run_q(run_q), .act_sel(act_sel),
    .act_div(act_div), .cnt(cnt)
);

// File: tb/gen_clk_div_tb_top.sv
`timescale 1ns/1ps
module gen_clk_div_tb_top;

    localparam int NS = 6;
    localparam int NV = 10;
    // Table: source code, divider field, lane driven (7 = all lanes), tick count, gap
    localparam int V_SEL [NV] = '{0, 1, 2, 5, 4, 6, 7, 3,   3,   0};
    localparam int V_DIV [NV] = '{0, 0, 1, 2, 4, 0, 0, 255, 255, 2};
    localparam int V_LANE[NV] = '{0, 1, 2, 5, 3, 7, 7, 3,   3,   7};
    localparam int V_N   [NV] = '{5, 6, 7, 9, 10, 5, 5, 512, 255, 6};
    localparam int V_GAP [NV] = '{0, 2, 1, 0, 0, 0, 1, 0,   0,   1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_tick = '0;
    logic [2:0]    cfg_sel = '0;
    logic [7:0]    cfg_div = '0;
    logic          cfg_en = 1'b0;
    logic          gen_tick;
    int            total = 0;
    int            bad = 0;
    int            got;
    bit            done = 0;

    always #10 clk = ~clk;

    gen_clk_div dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_sel(cfg_sel),
        .cfg_div(cfg_div), .cfg_en(cfg_en), .gen_tick(gen_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] lane_mask(input int lane);
        return (lane == 7) ? '1 : NS'(1) << lane;
    endfunction

    // Drive n ticks on a lane with gap idle cycles between, counting outputs.
    task automatic drive_ticks(input int lane, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); got += int'(gen_tick); src_tick = lane_mask(lane);
            for (int j = 0; j < gap; j++) begin
                @(negedge clk); got += int'(gen_tick); src_tick = '0;
            end
        end
        @(negedge clk); got += int'(gen_tick); src_tick = '0;
        for (int j = 0; j < 2; j++) begin
            @(negedge clk); got += int'(gen_tick);
        end
    endtask

    // Stop, load new fields, restart; ticks may follow at the next negedge.
    task automatic restart(input int sel, input int div);
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk); cfg_sel = 3'(sel); cfg_div = 8'(div);
        @(negedge clk); cfg_en = 1'b1;
        got = 0;
    endtask

    initial begin
        // R1: output quiet in reset even with the enable and all lanes ticking
        cfg_en = 1'b1; src_tick = '1; cfg_sel = 3'd2; cfg_div = 8'd1;
        repeat (3) @(negedge clk);
        check("R1 reset quiet", int'(gen_tick), 0);
        src_tick = '0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 post-reset quiet", int'(gen_tick), 0);
        got = 0;
        drive_ticks(2, 4, 0);
        check("R1 reset-loaded settings", got, 2);

        // Table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            int exp;
            bit ok;
            ok  = (V_SEL[i] < NS) && (V_LANE[i] == V_SEL[i] || V_LANE[i] == 7);
            exp = ok ? V_N[i] / (V_DIV[i] + 1) : 0;
            restart(V_SEL[i], V_DIV[i]);
            drive_ticks(V_LANE[i], V_N[i], V_GAP[i]);
            check($sformatf("R2/R3/R4/R5/R8 row %0d", i), got, exp);
        end

        // R4: single-tick latency and width
        restart(4, 0);
        @(negedge clk); src_tick = lane_mask(4);
        @(negedge clk); src_tick = '0;
        check("R4 tick next cycle", int'(gen_tick), 1);
        @(negedge clk);
        check("R4 one cycle wide", int'(gen_tick), 0);

        // R6: writes while running are ignored until the next restart
        restart(1, 0);
        @(negedge clk); cfg_sel = 3'd3; cfg_div = 8'd3;
        got = 0; drive_ticks(1, 4, 0);
        check("R6 old lane still used", got, 4);
        got = 0; drive_ticks(3, 4, 0);
        check("R6 new lane not yet used", got, 0);
        restart(3, 3);
        drive_ticks(3, 4, 0);
        check("R6 new settings after restart", got, 1);

        // R7: stop in the same cycle as a terminal tick
        restart(0, 0);
        @(negedge clk); src_tick = lane_mask(0); cfg_en = 1'b0;
        @(negedge clk); src_tick = '0;
        check("R7 stop within one cycle", int'(gen_tick), 0);

        // R7: partial count discarded, ticks while stopped ignored
        restart(0, 3);
        drive_ticks(0, 3, 0);
        check("R7 partial period silent", got, 0);
        @(negedge clk); cfg_en = 1'b0;
        got = 0; drive_ticks(0, 4, 0);
        check("R7 stopped ignores ticks", got, 0);
        @(negedge clk); cfg_en = 1'b1;
        got = 0; drive_ticks(0, 3, 0);
        check("R7 count restarted", got, 0);
        got = 0; drive_ticks(0, 1, 0);
        check("R7 full period after restart", got, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule